// File: doc/BRIEF.md
# Window Watchdog and Reset Sequencer

This block watches a microcontroller through rising edges on a trigger input and drives its active-low reset line. After power-up it holds the reset low for a long pulse. It then gives the software a lead time in which to send the first trigger. Once that trigger arrives, the block runs a repeating supervision cycle. Each cycle has a closed window, in which a trigger is forbidden, followed by an open window, in which a trigger is expected.

A trigger in the open window starts a fresh closed window. A trigger that comes too early, or no trigger by the end of the open window, produces a short reset. A missed first trigger produces another long reset. After any reset the block returns to the lead phase.

All durations are counted in clock cycles that carry an oscillator-enable tick. A supply-undervoltage input forces the long reset for as long as it is high. A status flag reports that the supervision cycle is running, meaning at least one trigger has been accepted since the last reset.

Top module: `wdog_rst_seq`

## Requirements
- R1: After `arst_ni` is released, `rst_no` stays low for exactly LONG_RST_TICKS enabled ticks and `sync_o` is 0 throughout. While `arst_ni` is low, `rst_no` and `sync_o` are both 0.
- R2: After a long reset ends, `rst_no` is high for at most LEAD_TICKS enabled ticks. If no trigger is accepted in that time, a new long reset of LONG_RST_TICKS ticks follows.
- R3: A trigger during the lead phase is accepted. It sets `sync_o` to 1 and starts a closed window.
- R4: Take the clock edge at which a closed window starts as tick 0. A trigger taking effect at enabled ticks 1 to CLOSE_TICKS produces a short reset: `rst_no` goes low for SHORT_RST_TICKS ticks, and the lead phase follows.
- R5: A trigger taking effect at ticks CLOSE_TICKS+1 to CLOSE_TICKS+OPEN_TICKS is accepted. This includes the last open-window tick. It restarts the closed window, with no reset, and `sync_o` stays 1.
- R6: If no trigger arrives by tick CLOSE_TICKS+OPEN_TICKS, a short reset of SHORT_RST_TICKS ticks begins at that tick.
- R7: When `uv_i` is high at a clock edge, `rst_no` is low after that edge. After `uv_i` falls, a full long reset of LONG_RST_TICKS ticks is counted from the first edge that sees `uv_i` low.
- R8: `sync_o` is 0 whenever `rst_no` is low.
- R9: Only a 0-to-1 transition of `wd_i` is a trigger. A level held high is not a repeated trigger. A transition that takes effect while reset is low is ignored.
- R10: Every phase advances only at clock edges where `tick_i` is 1. When ticks come every other cycle, each phase lasts twice as many clock cycles, within one cycle.
- R11: `wd_i` passes through a two-stage synchronizer. A rise first sampled at clock edge e takes effect at edge e+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | Oscillator-enable tick; the timing counters advance only when it is 1 |
| wd_i | input | 1 | Asynchronous trigger from the supervised controller |
| uv_i | input | 1 | Supply-undervoltage indication, forces reset while high |
| rst_no | output | 1 | Reset to the supervised controller, active low |
| sync_o | output | 1 | High once a trigger has been accepted since the last reset |

## Verification
The bench builds the block with a closed window of 6 ticks, an open window of 5, a long reset of 8, a lead time of 7 and a short reset of 5. At these values every phase length can be counted sample by sample. A sweep moves the second trigger across each tick of the closed window, the open window and past its end, so both window boundaries and the open-window expiry edge are checked against an arithmetic prediction. Ticking at half rate, undervoltage during a running cycle, triggers during reset, and a held-high trigger level are each checked in separate phases.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    WS_LONG_RST  = 3'd0,
    WS_LEAD      = 3'd1,
    WS_CLOSED    = 3'd2,
    WS_OPEN      = 3'd3,
    WS_SHORT_RST = 3'd4
  } wd_state_e;

  // Number of enabled ticks a phase lasts before it expires.
  function automatic int unsigned phase_len(
    input wd_state_e   st,
    input int unsigned long_t,
    input int unsigned lead_t,
    input int unsigned close_t,
    input int unsigned open_t,
    input int unsigned short_t
  );
    case (st)
      WS_LONG_RST:  return long_t;
      WS_LEAD:      return lead_t;
      WS_CLOSED:    return close_t;
      WS_OPEN:      return open_t;
      WS_SHORT_RST: return short_t;
      default:      return 1;
    endcase
  endfunction

  function automatic int unsigned max5(
    input int unsigned a, input int unsigned b, input int unsigned c,
    input int unsigned d, input int unsigned e
  );
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  function automatic logic is_reset_state(input wd_state_e st);
    return (st == WS_LONG_RST) || (st == WS_SHORT_RST);
  endfunction

endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, stab_q, prev_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign rise_o = stab_q & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rise_o |=> !rise_o);  // R9

endmodule

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)    cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wdog_seq_fsm.sv
module wdog_seq_fsm
  import wdog_pkg::*;
#(
  parameter int unsigned CLOSE_TICKS     = 980,
  parameter int unsigned OPEN_TICKS      = 780,
  parameter int unsigned LONG_RST_TICKS  = 5520,
  parameter int unsigned LEAD_TICKS      = 5520,
  parameter int unsigned SHORT_RST_TICKS = 162,
  parameter int unsigned CNT_W           = 13
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic tick_i,
  input  logic rise_i,
  input  logic uv_i,
  output logic rst_no,
  output logic sync_o
);
  wd_state_e        state_q, state_d;
  logic             sync_q, sync_d;
  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic             expire, restart, accept, in_rst, in_short, nxt_rst;

  wdog_tick_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .clr_i  (restart),
    .tick_i (tick_i),
    .cnt_o  (cnt_q)
  );

  assign lim_m1 = CNT_W'(phase_len(state_q, LONG_RST_TICKS, LEAD_TICKS,
                                   CLOSE_TICKS, OPEN_TICKS, SHORT_RST_TICKS) - 1);
  assign expire = tick_i && (cnt_q == lim_m1);

  always_comb begin
    state_d = state_q;
    case (state_q)
      WS_LONG_RST:  if (expire) state_d = WS_LEAD;
      WS_LEAD:      if (rise_i) state_d = WS_CLOSED;
                    else if (expire) state_d = WS_LONG_RST;
      WS_CLOSED:    if (rise_i) state_d = WS_SHORT_RST;
                    else if (expire) state_d = WS_OPEN;
      WS_OPEN:      if (rise_i) state_d = WS_CLOSED;
                    else if (expire) state_d = WS_SHORT_RST;
      WS_SHORT_RST: if (expire) state_d = WS_LEAD;
      default:      state_d = WS_LONG_RST;
    endcase
    if (uv_i) state_d = WS_LONG_RST;
  end

  assign restart  = (state_d != state_q) || uv_i;
  assign accept   = rise_i && !uv_i && ((state_q == WS_LEAD) || (state_q == WS_OPEN));
  assign nxt_rst  = is_reset_state(state_d);
  assign sync_d   = nxt_rst ? 1'b0 : (accept ? 1'b1 : sync_q);
  assign in_rst   = is_reset_state(state_q);
  assign in_short = (state_q == WS_SHORT_RST);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      state_q <= WS_LONG_RST;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sync_q  <= sync_d;
    end
  end

  assign rst_no = !in_rst;
  assign sync_o = sync_q;

  AST_UV_FORCES_RST: assert property (@(posedge clk_i) disable iff (!arst_ni)
    uv_i |=> !rst_no);  // R7
  AST_SYNC_LOW_IN_RST: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !rst_no |-> !sync_o);  // R8
  AST_CNT_IN_PHASE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    cnt_q <= lim_m1);  // R10
  AST_LONG_EXIT_TO_LEAD: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (state_q == WS_LONG_RST) |=> (state_q == WS_LONG_RST) || (state_q == WS_LEAD));  // R1
  AST_SHORT_FROM_WINDOW: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(in_short) |-> $past((state_q == WS_CLOSED) || (state_q == WS_OPEN)));  // R4
  AST_RST_IGNORES_EDGE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (in_rst && !expire) |=> in_rst);  // R9
  AST_SYNC_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(sync_o) |-> $past(rise_i));  // R3

endmodule

// File: rtl/wdog_rst_seq.sv
module wdog_rst_seq #(
  parameter int unsigned CLOSE_TICKS     = 980,
  parameter int unsigned OPEN_TICKS      = 780,
  parameter int unsigned LONG_RST_TICKS  = 5520,
  parameter int unsigned LEAD_TICKS      = 5520,
  parameter int unsigned SHORT_RST_TICKS = 162
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic tick_i,
  input  logic wd_i,
  input  logic uv_i,
  output logic rst_no,
  output logic sync_o
);
  localparam int unsigned MAX_T = wdog_pkg::max5(CLOSE_TICKS, OPEN_TICKS,
                                   LONG_RST_TICKS, LEAD_TICKS, SHORT_RST_TICKS);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic wd_rise;

  wdog_edge_sync u_edge (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .async_i(wd_i),
    .rise_o (wd_rise)
  );

  wdog_seq_fsm #(
    .CLOSE_TICKS    (CLOSE_TICKS),
    .OPEN_TICKS     (OPEN_TICKS),
    .LONG_RST_TICKS (LONG_RST_TICKS),
    .LEAD_TICKS     (LEAD_TICKS),
    .SHORT_RST_TICKS(SHORT_RST_TICKS),
    .CNT_W          (CNT_W)
  ) u_fsm (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .tick_i (tick_i),
    .rise_i (wd_rise),
    .uv_i   (uv_i),
    .rst_no (rst_no),
    .sync_o (sync_o)
  );

endmodule

// File: tb/wdog_rst_seq_tb.sv
module wdog_rst_seq_tb_top;
  localparam int CL = 6, OP = 5, LG = 8, LD = 7, SH = 5, LAT = 3;

  logic clk = 1'b0, arst_ni = 1'b0, tick = 1'b1, wd = 1'b0, uv = 1'b0, half = 1'b0;
  logic rst_no, sync_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= half ? ~tick : 1'b1;

  wdog_rst_seq #(.CLOSE_TICKS(CL), .OPEN_TICKS(OP), .LONG_RST_TICKS(LG),
                 .LEAD_TICKS(LD), .SHORT_RST_TICKS(SH)) dut_i (
    .clk_i(clk), .arst_ni(arst_ni), .tick_i(tick), .wd_i(wd), .uv_i(uv),
    .rst_no(rst_no), .sync_o(sync_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (rst_no == lvl && n < 1000) begin n++; @(negedge clk); end
  endtask

  // Drive a one-cycle trigger pulse; returns at the negedge after its effect edge.
  task automatic trig();
    wd = 1'b1; @(negedge clk); wd = 1'b0;
    repeat (LAT - 1) @(negedge clk);
  endtask

  task automatic back_to_lead();
    int n;
    n = 0;
    while (rst_no == 1'b1 && n < 1000) begin n++; @(negedge clk); end
    while (rst_no == 1'b0 && n < 2000) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(rst_no == 0 && sync_o == 0, "R1 reset state", {rst_no, sync_o}, 0);
    arst_ni = 1'b1;
    count_level(1'b0, n);
    chk(n == LG, "R1 power-on long reset length", n, LG);
    count_level(1'b1, n);
    chk(n == LD, "R2 lead timeout length", n, LD);
    // long reset repeats; fire a trigger inside it (R9 ignored in reset)
    wd = 1'b1; @(negedge clk); wd = 1'b0; @(negedge clk);
    count_level(1'b0, n);
    chk(n == LG - 2, "R2 repeated long reset length", n, LG - 2);
    chk(sync_o == 0, "R9 edge during reset not accepted (sync)", sync_o, 0);
    count_level(1'b1, n);
    chk(n == LD, "R9 edge during reset ignored, lead runs full", n, LD);
    @(negedge clk);

    // Window sweep: R3 R4 R5 R6 R11
    for (int k = 0; k <= CL + OP; k++) begin
      int d;
      bit ok;
      back_to_lead();
      trig();
      chk(sync_o == 1 && rst_no == 1, "R3 lead trigger accepted", sync_o, 1);
      repeat (k) @(negedge clk);
      trig();
      d = k + LAT;
      ok = (d > CL) && (d <= CL + OP);
      if (ok) begin
        chk(rst_no == 1, "R5 open-window trigger no reset", rst_no, 1);
        chk(sync_o == 1, "R5 sync stays high", sync_o, 1);
      end else begin
        chk(rst_no == 0, (d <= CL) ? "R4 closed-window trigger resets" :
                                     "R6 missed open window resets", rst_no, 0);
        chk(sync_o == 0, "R8 sync cleared by reset", sync_o, 0);
        if (d <= CL) begin
          count_level(1'b0, n);
          chk(n == SH, "R4 short reset length", n, SH);
        end
      end
      if (k == CL + OP - LAT) begin
        // last accepted offset: closed window restarted, expect expiry after CL+OP
        count_level(1'b1, n);
        chk(n == CL + OP, "R6 window expiry after restart", n, CL + OP);
      end
    end

    // Held-high level is one trigger only (R9)
    back_to_lead();
    wd = 1'b1;
    repeat (LAT) @(negedge clk);
    n = 0;
    for (int i = 0; i < CL + 2; i++) begin
      if (rst_no == 1) n++;
      @(negedge clk);
    end
    chk(n == CL + 2, "R9 held level not retriggered", n, CL + 2);
    wd = 1'b0;

    // Undervoltage during a running cycle (R7 R8)
    back_to_lead();
    trig();
    uv = 1'b1;
    @(negedge clk);
    chk(rst_no == 0, "R7 uv forces reset", rst_no, 0);
    chk(sync_o == 0, "R8 sync cleared by uv reset", sync_o, 0);
    repeat (4) @(negedge clk);
    uv = 1'b0;
    count_level(1'b0, n);
    chk(n == LG, "R7 full long reset after uv release", n, LG);

    // Half-rate ticks (R10)
    arst_ni = 1'b0; half = 1'b1;
    repeat (2) @(negedge clk);
    arst_ni = 1'b1;
    count_level(1'b0, n);
    chk(n >= 2 * LG - 1 && n <= 2 * LG, "R10 half-rate long reset", n, 2 * LG);
    half = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule